// File: doc/BRIEF.md
# Watchdog Timer with Guarded Configuration

This block is a watchdog timer whose control state (run enable and prescaler select) can only be changed in set ways. How strict those ways are depends on a safety level that is sampled while reset is held. A register-write port carries a change-unlock bit, an enable bit and a 3-bit prescaler select. Software restarts the counter through a kick input. When the prescaled count expires, the block raises a reset request for one cycle.

The least strict level lets software start the timer and retune the prescaler freely. Only stopping a running timer needs the guarded procedure. The middle level also guards prescaler changes. The strictest level keeps the timer running at all times and guards the prescaler.

The guarded procedure has two steps. First comes an unlock write that has both the change-unlock bit and the enable bit at one. This opens a short window. Then one follow-up write, with the change-unlock bit at zero, lands inside that window. The window closes by itself if no such write arrives.

Top module: `wdog_guard`

## Requirements
- R1: While `rstN` is low, the block takes its level from `safetyLevel`: 0 is free, 1 is guarded, 2 or 3 is locked. After reset the prescaler select is 0, the window is closed and `rstReq` is 0. The enable is 0 at the free and guarded levels and 1 at the locked level. The read-back layout is bits [2:0] prescaler select, bit 3 enable, bit 4 window open. The write layout is bits [2:0] select, bit 3 enable, bit 4 change-unlock.
- R2: At the free level, a write with change-unlock 0 outside the window loads the select bits. If its enable bit is 1, it also sets the enable.
- R3: At the free and guarded levels, the enable only goes from 1 to 0 through a follow-up write inside an open window. A write with enable 0 outside the window leaves the enable at 1.
- R4: A write with change-unlock 1 and enable 1 opens the window, and bit 4 reads 1. With no further write, the window stays open for four cycles and then reads 0.
- R5: The first write with change-unlock 0 in any of the four cycles after the unlock applies both its enable and select bits, and it closes the window.
- R6: At the guarded level, a write outside the window may set the enable but never changes the select.
- R7: At the locked level, the enable reads 1 at all times. The select changes only through the window, and the enable bit of the follow-up write is ignored.
- R8: A write with change-unlock 1 and enable 0 does not open the window.
- R9: While enabled, `rstReq` is high for exactly one cycle, 2^(BASE_EXP+sel) cycles after the counter last restarted. The counter restarts on enable, on a kick, and when the select value changes.
- R10: A kick restarts the count, so the request comes a full period after the last kick.
- R11: Changes on `safetyLevel` while `rstN` is high have no effect.
- R12: A follow-up write on the fifth cycle after the unlock, or later, is treated as an ordinary write and makes no guarded change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| safetyLevel | input | 2 | Strictness level, sampled only during reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 5 | Write data: select [2:0], enable [3], change-unlock [4] |
| kick | input | 1 | Restart the timeout counter |
| rdData | output | 5 | Read-back: select [2:0], enable [3], window open [4] |
| rstReq | output | 1 | One-cycle reset request on timeout |

## Verification
The bench builds the block with BASE_EXP = 2, so a period is 4 << sel cycles instead of the default 16384 << sel. With that setting the exact expiry cycle, the one-cycle pulse and the restart by kick or by a select change can each be observed within a few dozen cycles. The window length stays at its default of four, so the last accepted cycle and the first rejected cycle are both checked directly.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int SEL_W   = 3;
  localparam int BIT_EN  = SEL_W;
  localparam int BIT_CHG = SEL_W + 1;
  localparam int REG_W   = SEL_W + 2;

  typedef enum logic [1:0] {
    LVL_FREE   = 2'd0,
    LVL_GUARD  = 2'd1,
    LVL_LOCKED = 2'd2
  } lvl_e;

  typedef struct packed {
    logic             run;
    logic             clr;
    logic [SEL_W-1:0] sel;
  } dp_cmd_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int WIN_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       safetyLevel,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             kick,
  output logic [REG_W-1:0] rdData,
  output logic [1:0]       lvl,
  output dp_cmd_t          dpCmd
);
  localparam int WIN_W = $clog2(WIN_CYCLES + 1);

  lvl_e             lvlQ;
  logic             enQ, enNext;
  logic [SEL_W-1:0] selQ, selNext;
  logic [WIN_W-1:0] winCnt, winNext;
  logic             winOpen, unlockWr, guardedWr;
  logic             isFree, isLocked;
  lvl_e             lvlIn;

  always_comb begin
    lvlIn = (safetyLevel == 2'd0) ? LVL_FREE :
            (safetyLevel == 2'd1) ? LVL_GUARD : LVL_LOCKED;
  end

  assign isFree    = (lvlQ == LVL_FREE);
  assign isLocked  = (lvlQ == LVL_LOCKED);
  assign winOpen   = (winCnt != '0);
  assign unlockWr  = wrEn && wrData[BIT_CHG] && wrData[BIT_EN];
  assign guardedWr = wrEn && !wrData[BIT_CHG] && winOpen;

  always_comb begin
    enNext  = enQ;
    selNext = selQ;
    winNext = winOpen ? winCnt - WIN_W'(1) : '0;
    if (wrEn) begin
      winNext = unlockWr ? WIN_W'(WIN_CYCLES) : '0;
      if (guardedWr) begin
        selNext = wrData[SEL_W-1:0];
        if (!isLocked) enNext = wrData[BIT_EN];
      end else begin
        if (!isLocked && wrData[BIT_EN]) enNext = 1'b1;
        if (isFree) selNext = wrData[SEL_W-1:0];
      end
    end
    if (isLocked) enNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lvlQ   <= lvlIn;
      enQ    <= (lvlIn == LVL_LOCKED);
      selQ   <= '0;
      winCnt <= '0;
    end else begin
      enQ    <= enNext;
      selQ   <= selNext;
      winCnt <= winNext;
    end
  end

  always_comb begin
    dpCmd.run = enQ;
    dpCmd.clr = kick || (rstN && (selNext != selQ));
    dpCmd.sel = selNext;
  end

  assign rdData = {winOpen, enQ, selQ};
  assign lvl    = lvlQ;
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int BASE_EXP = 14
) (
  input  logic    clk,
  input  logic    rstN,
  input  dp_cmd_t dpCmd,
  output logic    rstReq
);
  localparam int CNT_W = BASE_EXP + (1 << SEL_W);

  logic [CNT_W-1:0] cnt, lastCnt;

  always_comb begin
    lastCnt = (CNT_W'(1) << (BASE_EXP + int'(dpCmd.sel))) - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN || dpCmd.clr || !dpCmd.run) begin
      cnt    <= '0;
      rstReq <= 1'b0;
    end else if (cnt == lastCnt) begin
      cnt    <= '0;
      rstReq <= 1'b1;
    end else begin
      cnt    <= cnt + CNT_W'(1);
      rstReq <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int BASE_EXP   = 14,
  parameter int WIN_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       safetyLevel,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             kick,
  output logic [REG_W-1:0] rdData,
  output logic             rstReq
);
  dp_cmd_t    dpCmd;
  logic [1:0] lvl;

  wdog_ctrl #(.WIN_CYCLES(WIN_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .safetyLevel(safetyLevel), .wrEn(wrEn),
    .wrData(wrData), .kick(kick), .rdData(rdData), .lvl(lvl), .dpCmd(dpCmd)
  );

  wdog_count #(.BASE_EXP(BASE_EXP)) u_count (
    .clk(clk), .rstN(rstN), .dpCmd(dpCmd), .rstReq(rstReq)
  );
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk
  import wdog_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [REG_W-1:0] wrData,
  input logic             kick,
  input logic [REG_W-1:0] rdData,
  input logic             rstReq,
  input logic [1:0]       lvl
);
  AST_EN_FALL_GUARDED: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdData[BIT_EN]) |-> $past(wrEn && rdData[BIT_CHG] && !wrData[BIT_CHG])); // R3

  AST_WIN_OPEN_SRC: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdData[BIT_CHG]) |-> $past(wrEn && wrData[BIT_CHG] && wrData[BIT_EN])); // R4

  AST_SEL_GUARDED: assert property (@(posedge clk) disable iff (!rstN)
    (lvl != LVL_FREE && !$stable(rdData[SEL_W-1:0]))
      |-> $past(wrEn && rdData[BIT_CHG] && !wrData[BIT_CHG])); // R6

  AST_LOCKED_EN: assert property (@(posedge clk) disable iff (!rstN)
    (lvl == LVL_LOCKED) |-> rdData[BIT_EN]); // R7

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq); // R9

  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> $past(rdData[BIT_EN])); // R9

  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    kick |=> !rstReq); // R10
endmodule

bind wdog_guard wdog_guard_chk u_chk (.*);

// File: tb/wdog_guard_tb.sv
module wdog_guard_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] safetyLevel = 2'd0;
  logic       wrEn = 1'b0;
  logic [4:0] wrData = '0;
  logic       kick = 1'b0;
  logic [4:0] rdData;
  logic       rstReq;
  int vectors = 0;
  int miscompares = 0;

  always #4 clk = ~clk;

  wdog_guard #(.BASE_EXP(2), .WIN_CYCLES(4)) u_dut (
    .clk(clk), .rstN(rstN), .safetyLevel(safetyLevel), .wrEn(wrEn),
    .wrData(wrData), .kick(kick), .rdData(rdData), .rstReq(rstReq)
  );

  function automatic logic [4:0] mk(input logic chg, input logic en, input logic [2:0] sel);
    return {chg, en, sel};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic doKick();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic doReset(input logic [1:0] l);
    rstN = 1'b0; safetyLevel = l;
    idle(3);
    rstN = 1'b1;
  endtask

  task automatic testFree();
    doReset(2'd0);
    check("R1 free reset", {27'd0, rdData}, mk(0, 0, 0));
    check("R1 no request", rstReq, 0);
    wr(mk(0, 1, 3'd3));
    check("R2 free enable+sel", rdData, mk(0, 1, 3'd3));
    wr(mk(0, 0, 3'd3));
    check("R3 plain disable ignored", rdData, mk(0, 1, 3'd3));
    wr(mk(1, 0, 3'd3));
    check("R8 no window without enable", rdData, mk(0, 1, 3'd3));
    wr(mk(1, 1, 3'd3));
    check("R4 window opens", rdData, mk(1, 1, 3'd3));
    idle(3);
    check("R4 still open cycle 4", rdData[4], 1);
    wr(mk(0, 0, 3'd1));
    check("R5 guarded disable on last cycle", rdData, mk(0, 0, 3'd1));
    wr(mk(1, 1, 3'd1));
    idle(4);
    check("R4 window self-closes", rdData[4], 0);
  endtask

  task automatic testGuard();
    doReset(2'd1);
    check("R1 guard reset", rdData, mk(0, 0, 0));
    safetyLevel = 2'd2;
    idle(1);
    check("R11 level input ignored", rdData[3], 0);
    wr(mk(0, 1, 3'd5));
    check("R6 enable free, sel kept", rdData, mk(0, 1, 3'd0));
    wr(mk(1, 1, 3'd0));
    wr(mk(0, 0, 3'd6));
    check("R5 guarded write first cycle", rdData, mk(0, 0, 3'd6));
    wr(mk(0, 1, 3'd0));
    check("R6 enable again", rdData, mk(0, 1, 3'd6));
    wr(mk(1, 1, 3'd6));
    idle(4);
    wr(mk(0, 0, 3'd1));
    check("R12 late write rejected", rdData, mk(0, 1, 3'd6));
  endtask

  task automatic testLocked();
    doReset(2'd2);
    check("R1 locked reset", rdData, mk(0, 1, 0));
    check("R1 locked no request", rstReq, 0);
    wr(mk(0, 0, 3'd3));
    check("R7 plain write ignored", rdData, mk(0, 1, 0));
    wr(mk(1, 0, 3'd0));
    check("R8 unlock needs enable bit", rdData[4], 0);
    wr(mk(1, 1, 3'd0));
    check("R7 window opens", rdData, mk(1, 1, 0));
    wr(mk(0, 0, 3'd2));
    check("R7 sel applied, enable stays", rdData, mk(0, 1, 3'd2));
  endtask

  task automatic testTimeout();
    // locked level, sel=2 -> period 16
    doKick();
    idle(15);
    check("R9 no request before period", rstReq, 0);
    idle(1);
    check("R9 request at period", rstReq, 1);
    idle(1);
    check("R9 single cycle pulse", rstReq, 0);
    doKick();
    idle(13);
    doKick();
    idle(15);
    check("R10 kick restarts count", rstReq, 0);
    idle(1);
    check("R10 request after last kick", rstReq, 1);
    wr(mk(1, 1, 3'd2));
    wr(mk(0, 1, 3'd0));
    idle(3);
    check("R9 sel change restart, early", rstReq, 0);
    idle(1);
    check("R9 sel 0 period of 4", rstReq, 1);
  endtask

  initial begin
    idle(1);
    testFree();
    testGuard();
    testLocked();
    testTimeout();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule